// File: doc/BRIEF.md
# Branch Target Buffer with Return Address Stack

This fetch-stage predictor looks at the address being fetched and, in the same cycle, says whether that address is a known branch, whether the branch is likely taken, and which address to fetch next. Known branches sit in a direct-mapped table. Each entry holds the upper bits of the branch address as a tag, a target address and a 2-bit saturating direction counter. A stored target is used only when the tag matches the whole upper part of the fetch address. Any other address is treated as a non-branch, and fetch goes on sequentially.

Procedure returns are predicted by a small circular stack rather than by the table. The fetch side asserts a push strobe on a call and a pop strobe on a return. Resolved branches come back through an update port. This port trains the counters, rewrites targets and allocates entries for taken branches that missed.

Top module: `btb_ras`

## Requirements
- R1: After reset every table entry is invalid. hit and pred_taken read 0, next_pc reads fetch_pc+4, and the stack is empty.
- R2: hit is 1 only when the entry selected by fetch_pc[IDX_W+1:2] is valid and its stored tag equals fetch_pc[ADDR_W-1:IDX_W+2]. An aliasing address with a different tag misses and gets next_pc = fetch_pc+4.
- R3: A taken update that misses allocates the entry with its tag and target and a weakly-taken counter (2). A later fetch of that address hits and predicts the target. This may evict an aliasing entry.
- R4: A not-taken update that misses leaves the table unchanged.
- R5: On a hit, a conditional update moves the counter up on taken and down on not-taken, saturating at 0 and 3. Counter values 2 and 3 predict taken, so the prediction from a saturated counter flips only after two opposite outcomes.
- R6: A taken update that hits replaces the stored target.
- R7: An update with upd_uncond set that hits (or allocates) sets the counter to 3.
- R8: ras_push stores fetch_pc+4. A ras_pop with a non-empty stack returns the most recent value as next_pc with pred_taken = 1, overriding any table prediction. Values come back in LIFO order.
- R9: A ras_pop on an empty stack gives next_pc = fetch_pc+4 and pred_taken = 0.
- R10: A push onto a full stack of RAS_DEPTH values overwrites the oldest value, so only the newest RAS_DEPTH values can be popped.
- R11: A push and a pop in the same cycle return the old top as next_pc and replace that top with fetch_pc+4, leaving the depth unchanged.
- R12: The prediction is combinational from fetch_pc. An update in the same cycle takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | ADDR_W | Address being fetched |
| ras_push | input | 1 | Call at fetch_pc: push fetch_pc+4 |
| ras_pop | input | 1 | Return at fetch_pc: take target from stack |
| upd_valid | input | 1 | Resolved branch present |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome |
| upd_uncond | input | 1 | Branch is unconditional |
| upd_target | input | ADDR_W | Resolved target |
| hit | output | 1 | Table tag match at fetch_pc |
| pred_taken | output | 1 | Predicted redirect |
| next_pc | output | ADDR_W | Predicted next fetch address |

## Verification
A call and a return can arrive in the same fetch cycle. The stack must then read its old top for next_pc and overwrite that same slot with the new return address. The bench provokes this by pushing once, then driving push and pop together. It judges the result by the next_pc of that cycle and by the next two pops: the first must return the address pushed in the combined cycle, and the second must find the stack empty. A second overlap, a table update landing on the address being looked up, is judged by the lookup seeing the old contents.

// File: rtl/btb_ras.sv
module btb_ras #(
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = 4,
  parameter int RAS_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] fetch_pc,
  input  logic              ras_push,
  input  logic              ras_pop,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic              upd_taken,
  input  logic              upd_uncond,
  input  logic [ADDR_W-1:0] upd_target,
  output logic              hit,
  output logic              pred_taken,
  output logic [ADDR_W-1:0] next_pc
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = ADDR_W - IDX_W - 2;
  localparam int PTR_W   = $clog2(RAS_DEPTH);
  localparam int CNT_W   = $clog2(RAS_DEPTH + 1);

  logic [ENTRIES-1:0] vld;
  logic [TAG_W-1:0]   tags [ENTRIES];
  logic [ADDR_W-1:0]  tgts [ENTRIES];
  logic [1:0]         ctrs [ENTRIES];
  logic [ADDR_W-1:0]  stk  [RAS_DEPTH];
  logic [PTR_W-1:0]   ptr, ptr_a;
  logic [CNT_W-1:0]   cnt, cnt_a;

  wire [IDX_W-1:0]  fidx = fetch_pc[IDX_W+1:2];
  wire [TAG_W-1:0]  ftag = fetch_pc[ADDR_W-1:IDX_W+2];
  wire [IDX_W-1:0]  uidx = upd_pc[IDX_W+1:2];
  wire [TAG_W-1:0]  utag = upd_pc[ADDR_W-1:IDX_W+2];
  wire [ADDR_W-1:0] seq_pc = fetch_pc + ADDR_W'(4);
  wire              umatch = vld[uidx] && (tags[uidx] == utag);
  wire              pop_ok = ras_pop && (cnt != '0);
  wire [ADDR_W-1:0] top    = stk[PTR_W'(ptr - 1'b1)];
  wire              tbl_tk = hit && ctrs[fidx][1];

  assign hit        = vld[fidx] && (tags[fidx] == ftag);
  assign pred_taken = ras_pop ? pop_ok : tbl_tk;
  assign next_pc    = ras_pop ? (pop_ok ? top : seq_pc)
                              : (tbl_tk ? tgts[fidx] : seq_pc);

  assign ptr_a = pop_ok ? PTR_W'(ptr - 1'b1) : ptr;
  assign cnt_a = pop_ok ? CNT_W'(cnt - 1'b1) : cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) vld <= '0;
    else if (upd_valid && !umatch && upd_taken) vld[uidx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (upd_valid) begin
      if (umatch) begin
        if (upd_taken) tgts[uidx] <= upd_target;
        if (upd_uncond)     ctrs[uidx] <= 2'b11;
        else if (upd_taken) ctrs[uidx] <= (ctrs[uidx] == 2'b11) ? 2'b11 : ctrs[uidx] + 2'b01;
        else                ctrs[uidx] <= (ctrs[uidx] == 2'b00) ? 2'b00 : ctrs[uidx] - 2'b01;
      end else if (upd_taken) begin
        tags[uidx] <= utag;
        tgts[uidx] <= upd_target;
        ctrs[uidx] <= upd_uncond ? 2'b11 : 2'b10;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
      cnt <= '0;
    end else if (ras_push) begin
      ptr <= PTR_W'(ptr_a + 1'b1);
      cnt <= (cnt_a == CNT_W'(RAS_DEPTH)) ? cnt_a : CNT_W'(cnt_a + 1'b1);
    end else begin
      ptr <= ptr_a;
      cnt <= cnt_a;
    end
  end

  always_ff @(posedge clk) begin
    if (ras_push) stk[ptr_a] <= seq_pc;
  end
endmodule

module btb_ras_chk #(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 3,
  parameter int RAS_DEPTH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] fetch_pc,
  input logic              ras_push,
  input logic              ras_pop,
  input logic              upd_valid,
  input logic [ADDR_W-1:0] upd_pc,
  input logic              upd_taken,
  input logic              hit,
  input logic              pred_taken,
  input logic [ADDR_W-1:0] next_pc,
  input logic [CNT_W-1:0]  cnt
);
  // R2
  table_redirect_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_taken && !ras_pop) |-> hit);

  // R9
  no_redirect_is_sequential_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_taken |-> (next_pc == fetch_pc + ADDR_W'(4)));

  // R3
  taken_update_then_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken) |=> ((fetch_pc != $past(upd_pc)) || hit));

  // R8
  pop_returns_last_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ras_push && !ras_pop) && ras_pop && !ras_push)
      |-> (pred_taken && next_pc == $past(fetch_pc) + ADDR_W'(4)));

  // R10
  stack_depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(RAS_DEPTH));
endmodule

bind btb_ras btb_ras_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .RAS_DEPTH(RAS_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .ras_push(ras_push), .ras_pop(ras_pop),
  .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken), .hit(hit),
  .pred_taken(pred_taken), .next_pc(next_pc), .cnt(cnt));

// File: tb/tb_btb_ras.sv
module tb_btb_ras;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_pc = '0, upd_pc = '0, upd_target = '0;
  logic        ras_push = 1'b0, ras_pop = 1'b0, upd_valid = 1'b0, upd_taken = 1'b0, upd_uncond = 1'b0;
  logic        hit, pred_taken;
  logic [31:0] next_pc;
  int          n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  btb_ras dut (.clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .ras_push(ras_push), .ras_pop(ras_pop),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_uncond(upd_uncond),
    .upd_target(upd_target), .hit(hit), .pred_taken(pred_taken), .next_pc(next_pc));

  typedef struct packed {
    logic [31:0] pc;
    logic        uv;
    logic [31:0] upc;
    logic        ut, uu;
    logic [31:0] utgt;
    logic        eh, et;
    logic [31:0] en;
    logic [7:0]  rq;
  } vec_t;

  // index bits are pc[5:2]; 0x100 and 0x1100 alias on entry 0
  localparam vec_t VEC [17] = '{
    '{32'h100, 1, 32'h100, 1, 0, 32'h800, 0, 0, 32'h104, 8'd12}, // R1 R12 alloc, lookup sees old
    '{32'h100, 1, 32'h100, 0, 0, 32'h0,   1, 1, 32'h800, 8'd3},  // R3 weak taken -> 1
    '{32'h100, 1, 32'h100, 1, 0, 32'h800, 1, 0, 32'h104, 8'd5},  // R5 -> 2
    '{32'h100, 1, 32'h100, 1, 0, 32'h800, 1, 1, 32'h800, 8'd5},  // R5 -> 3
    '{32'h100, 1, 32'h100, 0, 0, 32'h0,   1, 1, 32'h800, 8'd5},  // R5 -> 2
    '{32'h100, 1, 32'h100, 0, 0, 32'h0,   1, 1, 32'h800, 8'd5},  // R5 -> 1
    '{32'h100, 1, 32'h100, 0, 0, 32'h0,   1, 0, 32'h104, 8'd5},  // R5 -> 0
    '{32'h100, 1, 32'h100, 0, 0, 32'h0,   1, 0, 32'h104, 8'd5},  // R5 stays 0
    '{32'h100, 1, 32'h100, 1, 0, 32'h900, 1, 0, 32'h104, 8'd5},  // R5 -> 1, R6 target 0x900
    '{32'h100, 1, 32'h100, 1, 0, 32'h900, 1, 0, 32'h104, 8'd5},  // R5 -> 2
    '{32'h100, 1, 32'h1100,0, 0, 32'h0,   1, 1, 32'h900, 8'd6},  // R6 new target; R4 NT miss
    '{32'h1100,1, 32'h1100,1, 1, 32'hA00, 0, 0, 32'h1104,8'd4},  // R4 R2 alias misses; R7 alloc
    '{32'h1100,1, 32'h1100,0, 0, 32'h0,   1, 1, 32'hA00, 8'd7},  // R7 3 -> 2
    '{32'h1100,1, 32'h1100,1, 1, 32'hA00, 1, 1, 32'hA00, 8'd7},  // R7 uncond -> 3
    '{32'h1100,1, 32'h1100,0, 0, 32'h0,   1, 1, 32'hA00, 8'd7},  // R7 3 -> 2
    '{32'h1100,0, 32'h0,   0, 0, 32'h0,   1, 1, 32'hA00, 8'd7},  // R7
    '{32'h100, 0, 32'h0,   0, 0, 32'h0,   0, 0, 32'h104, 8'd2}   // R2 evicted by alias
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input int rq, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] pc, input logic psh, input logic pp, input logic uv,
                      input logic [31:0] upc, input logic ut, input logic uu, input logic [31:0] utgt,
                      input logic eh, input logic et, input logic [31:0] en, input int rq);
    @(negedge clk);
    fetch_pc = pc; ras_push = psh; ras_pop = pp;
    upd_valid = uv; upd_pc = upc; upd_taken = ut; upd_uncond = uu; upd_target = utgt;
    #1;
    chk({31'b0, hit}, {31'b0, eh}, rq, "hit");
    chk({31'b0, pred_taken}, {31'b0, et}, rq, "pred_taken");
    chk(next_pc, en, rq, "next_pc");
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    foreach (VEC[i])
      step(VEC[i].pc, 0, 0, VEC[i].uv, VEC[i].upc, VEC[i].ut, VEC[i].uu, VEC[i].utgt,
           VEC[i].eh, VEC[i].et, VEC[i].en, int'(VEC[i].rq));
    // R9 empty pop
    step(32'h200, 0, 1, 0, 0, 0, 0, 0, 0, 0, 32'h204, 9);
    // R8 LIFO, pop overrides a taken table hit
    step(32'h300, 1, 0, 0, 0, 0, 0, 0, 0, 0, 32'h304, 8);
    step(32'h310, 1, 0, 0, 0, 0, 0, 0, 0, 0, 32'h314, 8);
    step(32'h1100,0, 1, 0, 0, 0, 0, 0, 1, 1, 32'h314, 8);
    step(32'h400, 0, 1, 0, 0, 0, 0, 0, 0, 1, 32'h304, 8);
    step(32'h500, 0, 1, 0, 0, 0, 0, 0, 0, 0, 32'h504, 9);
    // R10 overflow drops oldest
    for (int k = 1; k <= 5; k++)
      step(32'(k * 16), 1, 0, 0, 0, 0, 0, 0, 0, 0, 32'(k * 16 + 4), 10);
    for (int k = 5; k >= 2; k--)
      step(32'h2000, 0, 1, 0, 0, 0, 0, 0, 0, 1, 32'(k * 16 + 4), 10);
    step(32'h2000, 0, 1, 0, 0, 0, 0, 0, 0, 0, 32'h2004, 10);
    // R11 push and pop together replace top
    step(32'h600, 1, 0, 0, 0, 0, 0, 0, 0, 0, 32'h604, 11);
    step(32'h700, 1, 1, 0, 0, 0, 0, 0, 0, 1, 32'h604, 11);
    step(32'h800, 0, 1, 0, 0, 0, 0, 0, 0, 1, 32'h704, 11);
    step(32'h900, 0, 1, 0, 0, 0, 0, 0, 0, 0, 32'h904, 11);
    // R1 reset clears table and stack
    step(32'h300, 1, 0, 0, 0, 0, 0, 0, 0, 0, 32'h304, 1);
    @(negedge clk) begin rst_n = 1'b0; ras_push = 1'b0; end
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    step(32'h1100, 0, 0, 0, 0, 0, 0, 0, 0, 0, 32'h1104, 1);
    step(32'h1000, 0, 1, 0, 0, 0, 0, 0, 0, 0, 32'h1004, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule